// File: doc/BRIEF.md
# One-Hot Result Completion Sequencer

This block paces a combinational stage whose result lines are one-hot. It alternates the stage between a precharge phase and an evaluate phase. During evaluation it watches the result lines. The single line that rises selects a downstream operation. A small per-line controller then raises that line's go and acknowledge outputs together. No wide OR over the result lines sits in front of the launch.

Any raised acknowledge ends the evaluation and starts a precharge phase. That phase has a fixed, parameter-set length and is timed by a counter rather than sensed. A new evaluation is accepted only after precharge has been released. Each go output stays high until its downstream operation returns a done pulse. An evaluation that shows more than one result line high launches nothing and sets a sticky error flag. The block is modelled as a clocked synchronous equivalent of the self-timed scheme.

Top module: `onehot_eval_sequencer`

## Requirements
- R1: While reset is asserted, prechargeOut is 1 and goOut, ackOut and errFlag are all 0. The first precharge after reset release lasts PRE_CYCLES cycles, counting the release cycle.
- R2: In the evaluate phase, when evalReq is 1 and exactly one result line i is high at a clock edge, goOut[i] and ackOut[i] are both 1 after that edge, and no other ack bit is set.
- R3: At most one bit of ackOut is high at any time.
- R4: The cycle after an acknowledge first rises, prechargeOut is 1.
- R5: Every precharge phase keeps prechargeOut high for exactly PRE_CYCLES consecutive cycles (default 4).
- R6: Result lines and evalReq are ignored while prechargeOut is 1. The evaluation launches in the first cycle after release.
- R7: In the evaluate phase, result lines are ignored while evalReq is 0.
- R8: If evalReq is 1 and two or more result lines are high in the evaluate phase, errFlag becomes 1, no go or ack is raised, and precharge starts the next cycle. errFlag stays 1 until reset.
- R9: ackOut[i] falls only after a cycle in which prechargeOut was 1 and resultIn[i] was 0.
- R10: goOut[i] stays high until doneIn[i] is sampled 1, and it falls the cycle after.
- R11: When a new launch on line i meets doneIn[i] in the same cycle, the launch wins and goOut[i] stays 1. A done on another line still clears that other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evalReq | input | 1 | Request to evaluate the result lines |
| resultIn | input | NUM_LINES | One-hot result lines from the combinational stage |
| doneIn | input | NUM_LINES | Per-line completion from downstream operations |
| goOut | output | NUM_LINES | Per-line start of downstream operation |
| ackOut | output | NUM_LINES | Per-line acknowledge of the result |
| prechargeOut | output | 1 | Precharge control for the combinational stage |
| errFlag | output | 1 | Sticky multi-hot error |

## Verification
A launch and a release can land on the same go bit in the same cycle. A new evaluation may select line i while the operation started by the previous launch of line i returns its done pulse. The bench leaves a go unanswered through one precharge. It then drives the next evaluation on the same line with doneIn for that line high in the same cycle, and requires the go bit to stay high. A second collision pairs a launch on one line with a done on another, and the bench requires the other line to clear while the new one sets.

// File: rtl/oes_pkg.sv
package oes_pkg;

  typedef enum logic [1:0] {
    PH_PRE   = 2'd0,
    PH_EVAL  = 2'd1,
    PH_ACKED = 2'd2
  } oesPhase_t;

  typedef struct packed {
    logic prechOn;
    logic launch;
    logic raiseErr;
    logic loadCnt;
    logic decCnt;
  } oesStrobes_t;

endpackage

// File: rtl/oes_control.sv
module oes_control
  import oes_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evalReq,
  input  logic        cntZero,
  input  logic        anyAck,
  input  logic        resSingle,
  input  logic        resMulti,
  output oesStrobes_t strobes
);

  oesPhase_t phase;
  oesPhase_t nextPhase;

  always_comb begin
    strobes   = '0;
    nextPhase = phase;
    unique case (phase)
      PH_PRE: begin
        strobes.prechOn = 1'b1;
        if (cntZero) nextPhase = PH_EVAL;
        else         strobes.decCnt = 1'b1;
      end
      PH_EVAL: begin
        if (evalReq) begin
          if (resMulti) begin
            strobes.raiseErr = 1'b1;
            strobes.loadCnt  = 1'b1;
            nextPhase        = PH_PRE;
          end else if (resSingle) begin
            strobes.launch = 1'b1;
            nextPhase      = PH_ACKED;
          end
        end
      end
      PH_ACKED: begin
        if (anyAck) begin
          strobes.loadCnt = 1'b1;
          nextPhase       = PH_PRE;
        end
      end
      default: begin
        strobes.loadCnt = 1'b1;
        nextPhase       = PH_PRE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_PRE;
    else       phase <= nextPhase;
  end

endmodule

// File: rtl/oes_datapath.sv
module oes_datapath
  import oes_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int PRE_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  oesStrobes_t          strobes,
  input  logic [NUM_LINES-1:0] resultIn,
  input  logic [NUM_LINES-1:0] doneIn,
  output logic [NUM_LINES-1:0] goOut,
  output logic [NUM_LINES-1:0] ackOut,
  output logic                 errFlag,
  output logic                 cntZero,
  output logic                 anyAck,
  output logic                 resSingle,
  output logic                 resMulti
);

  localparam int CW = (PRE_CYCLES > 1) ? $clog2(PRE_CYCLES) : 1;
  localparam int SW = $clog2(NUM_LINES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(PRE_CYCLES - 1);

  logic [CW-1:0] preCnt;
  logic [SW-1:0] hotCount;

  // population count of the result lines
  always_comb begin
    hotCount = '0;
    for (int k = 0; k < NUM_LINES; k++) hotCount = hotCount + SW'(resultIn[k]);
  end

  assign resSingle = (hotCount == SW'(1));
  assign resMulti  = (hotCount > SW'(1));
  assign cntZero   = (preCnt == '0);
  assign anyAck    = |ackOut;

  // precharge interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= CNT_LOAD;
    else if (strobes.loadCnt) preCnt <= CNT_LOAD;
    else if (strobes.decCnt)  preCnt <= preCnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 errFlag <= 1'b0;
    else if (strobes.raiseErr) errFlag <= 1'b1;
  end

  // one small controller per result line
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic goQ;
    logic ackQ;
    logic setLine;

    assign setLine = strobes.launch && resultIn[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        goQ  <= 1'b0;
        ackQ <= 1'b0;
      end else begin
        if (setLine)        goQ <= 1'b1;
        else if (doneIn[g]) goQ <= 1'b0;
        if (setLine)                               ackQ <= 1'b1;
        else if (strobes.prechOn && !resultIn[g])  ackQ <= 1'b0;
      end
    end

    assign goOut[g]  = goQ;
    assign ackOut[g] = ackQ;
  end

endmodule

// File: rtl/onehot_eval_sequencer.sv
module onehot_eval_sequencer
  import oes_pkg::*;
#(
  parameter int NUM_LINES  = 4,
  parameter int PRE_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evalReq,
  input  logic [NUM_LINES-1:0] resultIn,
  input  logic [NUM_LINES-1:0] doneIn,
  output logic [NUM_LINES-1:0] goOut,
  output logic [NUM_LINES-1:0] ackOut,
  output logic                 prechargeOut,
  output logic                 errFlag
);

  oesStrobes_t strobes;
  logic cntZero;
  logic anyAck;
  logic resSingle;
  logic resMulti;

  oes_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evalReq   (evalReq),
    .cntZero   (cntZero),
    .anyAck    (anyAck),
    .resSingle (resSingle),
    .resMulti  (resMulti),
    .strobes   (strobes)
  );

  oes_datapath #(
    .NUM_LINES  (NUM_LINES),
    .PRE_CYCLES (PRE_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .resultIn  (resultIn),
    .doneIn    (doneIn),
    .goOut     (goOut),
    .ackOut    (ackOut),
    .errFlag   (errFlag),
    .cntZero   (cntZero),
    .anyAck    (anyAck),
    .resSingle (resSingle),
    .resMulti  (resMulti)
  );

  assign prechargeOut = strobes.prechOn;

endmodule

// File: rtl/onehot_eval_sequencer_chk.sv
module onehot_eval_sequencer_chk #(
  parameter int NUM_LINES  = 4,
  parameter int PRE_CYCLES = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 evalReq,
  input logic [NUM_LINES-1:0] resultIn,
  input logic [NUM_LINES-1:0] doneIn,
  input logic [NUM_LINES-1:0] goOut,
  input logic [NUM_LINES-1:0] ackOut,
  input logic                 prechargeOut,
  input logic                 errFlag
);

  localparam int RW = $clog2(PRE_CYCLES + 1) + 1;

  logic [RW-1:0] runLen;

  // length of the current run of precharge cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             runLen <= '0;
    else if (prechargeOut) runLen <= runLen + RW'(1);
    else                   runLen <= '0;
  end

  p_ack_one_hot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOut));

  p_pre_follows_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|ackOut) |=> prechargeOut);

  p_pre_length_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(prechargeOut) |-> (runLen == RW'(PRE_CYCLES)));

  p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    prechargeOut |-> (runLen < RW'(PRE_CYCLES)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  p_err_no_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> ((ackOut == '0) && prechargeOut));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    p_ack_with_go_r2: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ackOut[g]) |-> goOut[g]);

    p_no_launch_in_pre_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ackOut[g]) |-> !$past(prechargeOut));

    p_launch_needs_req_r7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ackOut[g]) |-> ($past(evalReq) && $past(resultIn[g])));

    p_ack_release_r9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(ackOut[g]) |-> ($past(prechargeOut) && !$past(resultIn[g])));

    p_go_release_r10: assert property (@(posedge clk) disable iff (!rstN)
      $fell(goOut[g]) |-> $past(doneIn[g]));
  end

endmodule

bind onehot_eval_sequencer onehot_eval_sequencer_chk #(
  .NUM_LINES  (NUM_LINES),
  .PRE_CYCLES (PRE_CYCLES)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .evalReq      (evalReq),
  .resultIn     (resultIn),
  .doneIn       (doneIn),
  .goOut        (goOut),
  .ackOut       (ackOut),
  .prechargeOut (prechargeOut),
  .errFlag      (errFlag)
);

// File: tb/onehot_eval_sequencer_tb.sv
`timescale 1ns/1ps
module onehot_eval_sequencer_tb;

  localparam int NL  = 4;
  localparam int PRE = 4;

  // {result pattern[7:4], idle cycles before request[3:0]}
  localparam int NVEC = 8;
  localparam logic [7:0] VEC [NVEC] = '{
    8'h10, 8'h43, 8'h21, 8'h85, 8'h40, 8'h12, 8'h61, 8'hB0
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evalReq = 1'b0;
  logic [NL-1:0] resultIn = '0;
  logic [NL-1:0] doneIn = '0;
  logic [NL-1:0] goOut;
  logic [NL-1:0] ackOut;
  logic          prechargeOut;
  logic          errFlag;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycles   = 0;
  bit errExp   = 1'b0;

  onehot_eval_sequencer #(.NUM_LINES(NL), .PRE_CYCLES(PRE)) u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .evalReq      (evalReq),
    .resultIn     (resultIn),
    .doneIn       (doneIn),
    .goOut        (goOut),
    .ackOut       (ackOut),
    .prechargeOut (prechargeOut),
    .errFlag      (errFlag)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failCnt++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  task automatic checkEq(input string tag, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitEval();
    while (prechargeOut) @(negedge clk);
  endtask

  // counts negedges with precharge high, starting at the current one
  task automatic measurePre(output int n);
    n = 0;
    while (prechargeOut) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulseDone(input logic [NL-1:0] lines, input string tag);
    doneIn = lines;
    @(negedge clk);
    doneIn = '0;
    checkEq(tag, int'(goOut & lines), 0);
  endtask

  initial begin
    int n;
    logic [NL-1:0] pat;
    int hot;

    // R1: reset state
    repeat (3) @(negedge clk);
    checkEq("R1 precharge in reset", int'(prechargeOut), 1);
    checkEq("R1 go in reset", int'(goOut), 0);
    checkEq("R1 ack in reset", int'(ackOut), 0);
    checkEq("R1 err in reset", int'(errFlag), 0);

    // R6: request held during the first precharge is ignored
    rstN = 1'b1;
    evalReq = 1'b1;
    resultIn = 4'b0010;
    n = 0;
    while (prechargeOut) begin
      if (ackOut != '0) checkEq("R6 ack during precharge", int'(ackOut), 0);
      n++;
      @(negedge clk);
    end
    checkEq("R1 first precharge length", n, PRE);
    @(negedge clk);
    checkEq("R6 launch right after release ack", int'(ackOut), 2);
    checkEq("R6 launch right after release go", int'(goOut), 2);
    evalReq = 1'b0;
    resultIn = '0;
    @(negedge clk);
    waitEval();
    pulseDone(4'b0010, "R10 go clears on done");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      pat = VEC[v][7:4];
      hot = $countones(pat);
      waitEval();
      for (int d = 0; d < int'(VEC[v][3:0]); d++) begin
        resultIn = ~pat;
        evalReq  = 1'b0;
        @(negedge clk);
        checkEq("R7 no ack without request", int'(ackOut), 0);
        checkEq("R7 no go without request", int'(goOut), 0);
      end
      evalReq  = 1'b1;
      resultIn = pat;
      @(negedge clk);
      evalReq  = 1'b0;
      resultIn = '0;
      if (hot == 1) begin
        checkEq("R2 go on selected line", int'(goOut), int'(pat));
        checkEq("R2 R3 ack on selected line only", int'(ackOut), int'(pat));
        checkEq("R2 no precharge in ack cycle", int'(prechargeOut), 0);
        @(negedge clk);
        checkEq("R4 precharge after ack", int'(prechargeOut), 1);
        measurePre(n);
        checkEq("R5 precharge length", n, PRE);
        checkEq("R9 ack released after precharge", int'(ackOut), 0);
        checkEq("R10 go held until done", int'(goOut), int'(pat));
        pulseDone(pat, "R10 go clears on done");
      end else begin
        errExp = 1'b1;
        checkEq("R8 err on multi-hot", int'(errFlag), 1);
        checkEq("R8 no go on multi-hot", int'(goOut), 0);
        checkEq("R8 no ack on multi-hot", int'(ackOut), 0);
        checkEq("R8 precharge on multi-hot", int'(prechargeOut), 1);
        measurePre(n);
        checkEq("R5 precharge length after error", n, PRE);
      end
      checkEq("R8 sticky err", int'(errFlag), int'(errExp));
    end

    // R11: launch and done on the same line in the same cycle
    waitEval();
    evalReq = 1'b1; resultIn = 4'b0100;
    @(negedge clk);
    evalReq = 1'b0; resultIn = '0;
    @(negedge clk);
    waitEval();
    checkEq("R10 go held with no done", int'(goOut), 4);
    evalReq = 1'b1; resultIn = 4'b0100; doneIn = 4'b0100;
    @(negedge clk);
    evalReq = 1'b0; resultIn = '0; doneIn = '0;
    checkEq("R11 launch wins over done", int'(goOut), 4);
    checkEq("R11 ack on collided line", int'(ackOut), 4);
    @(negedge clk);
    waitEval();
    // launch on line 0 while line 2 completes
    evalReq = 1'b1; resultIn = 4'b0001; doneIn = 4'b0100;
    @(negedge clk);
    evalReq = 1'b0; resultIn = '0; doneIn = '0;
    checkEq("R11 other line clears, new line sets", int'(goOut), 1);
    @(negedge clk);
    waitEval();
    pulseDone(4'b0001, "R10 go clears on done");
    checkEq("R8 err still sticky", int'(errFlag), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule